// File: doc/BRIEF.md
# Flash Write-Status Polling Generator

This block produces the word a NOR-style flash array returns on a read while an internal program or erase runs. It takes the array's busy flag, the type of the running operation, the erase-suspend flag and the sector under erase from the surrounding array model. On each read it decides whether to return status bits or to pass the array data through unchanged.

Status replaces array data in three cases: a program is running, an erase is running, or the read hits the erase-suspended sector. Bit 7 is the data-polling bit. Bit 6 is a general toggle bit that flips on each status read while an operation is active. Bit 2 is a sector-specific toggle bit that flips only on reads of the sector being erased or the suspended sector. A read is taken on the rising edge of the read strobe. The returned word is registered and appears on `rd_data` in the cycle after that edge, and it holds until the next read.

Top module: `flash_status_poll`

## Requirements
- R1: While reset is high, `rd_data` is 0 and both toggle bits are cleared. The first status read after reset therefore returns bit 6 as 1.
- R2: A read is taken only on a rising edge of `rd_stb`, and its word appears on `rd_data` one clock later. A strobe held high over several cycles counts as a single read, and `rd_data` does not change without a new rising edge.
- R3: Bit 6 returns the inverse of its previous status value on each read that returns program or erase status. Reads that return array data or suspended-sector status leave it unchanged.
- R4: During a program (busy high, erase flag low), a read that does not hit a suspended sector returns bit 7 as the complement of `prog_bit` and bit 2 as 0. This also covers a program started while an erase is suspended.
- R5: During an erase that is not suspended (busy high, erase flag high, suspend low), bit 7 reads 0. Bit 2 flips on reads whose sector equals `erase_sector`. On reads of any other sector it repeats its last value.
- R6: With suspend high, a read of the suspended sector returns bit 7 = 1, bit 6 = 1 and a flipping bit 2, whatever the busy and erase flags are.
- R7: With suspend high and no program running, a read of any other sector returns `arr_data` unchanged.
- R8: With busy and suspend both low, a read returns `arr_data` unchanged.
- R9: When status is returned, bits 15:8, 5:3 and 1:0 are 0.
- R10: The sector of a read is the top SECT_W bits of `rd_addr`. The lower address bits do not affect the sector match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read strobe; a read is taken on its rising edge |
| rd_addr | input | ADDR_W | Read address; top SECT_W bits select the sector |
| arr_data | input | DATA_W | Array data returned when no status applies |
| prog_bit | input | 1 | Bit 7 of the data being programmed |
| busy | input | 1 | An internal program or erase is running |
| op_erase | input | 1 | Running or suspended operation is an erase (else program) |
| suspended | input | 1 | An erase is suspended |
| erase_sector | input | SECT_W | Sector being erased or suspended |
| rd_data | output | DATA_W | Registered read word |

## Verification
The bench targets these corner cases:
- Reads that should freeze bit 6: idle reads, suspended-sector reads, and a strobe held high for three cycles. A design that flips the toggle on every cycle of the strobe, or on reads that return no status, gets the bit 6 phase wrong on the next program read.
- Erase reads that alternate between the erased sector and a sector whose lower address bits are the same. A design that decodes the sector from the wrong address bits, or that flips bit 2 on every erase read, shows a bit 2 sequence that differs from the model.
- Suspend with a program running elsewhere. A design that puts the busy check before the suspended-sector check returns program status where 0xC0-style suspend status is expected.
- All-ones array data during status reads. This catches unused bits that leak through.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY    = 2'd0,
        RM_PROG     = 2'd1,
        RM_ERASE    = 2'd2,
        RM_SUSP_HIT = 2'd3
    } rd_mode_e;

    localparam int BIT_POLL = 7;
    localparam int BIT_TGL  = 6;
    localparam int BIT_ETGL = 2;

    typedef struct packed {
        logic poll;
        logic tgl;
        logic etgl;
    } stat_bits_t;

    // Suspended-sector reads win over a running program; suspend masks erase status.
    function automatic rd_mode_e pick_mode(
        input logic busy,
        input logic is_erase,
        input logic susp,
        input logic hit
    );
        if (susp && hit)
            return RM_SUSP_HIT;
        else if (busy && !is_erase)
            return RM_PROG;
        else if (busy && !susp)
            return RM_ERASE;
        else
            return RM_ARRAY;
    endfunction

endpackage

// File: rtl/fsp_sector_match.sv
module fsp_sector_match #(
    parameter int ADDR_W = 20,
    parameter int SECT_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SECT_W-1:0] sect,
    output logic              hit
);
    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic [SECT_W-1:0] addr_sect;

    assign addr_sect = addr[ADDR_W-1:SECT_LSB];
    assign hit       = (addr_sect == sect);
endmodule

// File: rtl/fsp_toggle.sv
module fsp_toggle (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic q,
    output logic nxt
);
    assign nxt = ~q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (en)
            q <= nxt;
    end
endmodule

// File: rtl/fsp_word_build.sv
module fsp_word_build #(
    parameter int DATA_W = 16
) (
    input  flash_stat_pkg::rd_mode_e   mode,
    input  flash_stat_pkg::stat_bits_t stat,
    input  logic [DATA_W-1:0]          arr,
    output logic [DATA_W-1:0]          word
);
    import flash_stat_pkg::*;

    always_comb begin
        if (mode == RM_ARRAY) begin
            word = arr;
        end else begin
            word           = '0;
            word[BIT_POLL] = stat.poll;
            word[BIT_TGL]  = stat.tgl;
            word[BIT_ETGL] = stat.etgl;
        end
    end
endmodule

// File: rtl/flash_status_poll.sv
module flash_status_poll #(
    parameter int ADDR_W = 20,
    parameter int SECT_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              prog_bit,
    input  logic              busy,
    input  logic              op_erase,
    input  logic              suspended,
    input  logic [SECT_W-1:0] erase_sector,
    output logic [DATA_W-1:0] rd_data
);
    import flash_stat_pkg::*;

    localparam int N_TGL = 2;
    localparam int T_DQ6 = 0;
    localparam int T_DQ2 = 1;

    logic       stb_q;
    logic       rise;
    logic       hit;
    rd_mode_e   mode;
    logic [N_TGL-1:0] tgl_en;
    logic [N_TGL-1:0] tgl_q;
    logic [N_TGL-1:0] tgl_nx;
    stat_bits_t stat;
    logic [DATA_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst)
            stb_q <= 1'b0;
        else
            stb_q <= rd_stb;
    end

    assign rise = rd_stb & ~stb_q;

    fsp_sector_match #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W)
    ) u_match (
        .addr (rd_addr),
        .sect (erase_sector),
        .hit  (hit)
    );

    assign mode = pick_mode(busy, op_erase, suspended, hit);

    assign tgl_en[T_DQ6] = rise && ((mode == RM_PROG) || (mode == RM_ERASE));
    assign tgl_en[T_DQ2] = rise && hit && ((mode == RM_ERASE) || (mode == RM_SUSP_HIT));

    generate
        for (genvar g = 0; g < N_TGL; g++) begin : g_tgl
            fsp_toggle u_tgl (
                .clk (clk),
                .rst (rst),
                .en  (tgl_en[g]),
                .q   (tgl_q[g]),
                .nxt (tgl_nx[g])
            );
        end
    endgenerate

    always_comb begin
        stat = '0;
        unique case (mode)
            RM_PROG: begin
                stat.poll = ~prog_bit;
                stat.tgl  = tgl_nx[T_DQ6];
                stat.etgl = 1'b0;
            end
            RM_ERASE: begin
                stat.poll = 1'b0;
                stat.tgl  = tgl_nx[T_DQ6];
                stat.etgl = hit ? tgl_nx[T_DQ2] : tgl_q[T_DQ2];
            end
            RM_SUSP_HIT: begin
                stat.poll = 1'b1;
                stat.tgl  = 1'b1;
                stat.etgl = tgl_nx[T_DQ2];
            end
            default: stat = '0;
        endcase
    end

    fsp_word_build #(
        .DATA_W (DATA_W)
    ) u_build (
        .mode (mode),
        .stat (stat),
        .arr  (arr_data),
        .word (word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rise)
            rd_data <= word;
    end
endmodule

// File: rtl/flash_status_poll_chk.sv
module flash_status_poll_chk #(
    parameter int ADDR_W = 20,
    parameter int SECT_W = 5,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_stb,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] arr_data,
    input logic              prog_bit,
    input logic              busy,
    input logic              op_erase,
    input logic              suspended,
    input logic [SECT_W-1:0] erase_sector,
    input logic [DATA_W-1:0] rd_data
);
    logic chk_stb_q;
    logic chk_rise;
    logic chk_hit;

    always_ff @(posedge clk) begin
        if (rst)
            chk_stb_q <= 1'b0;
        else
            chk_stb_q <= rd_stb;
    end

    assign chk_rise = rd_stb && !chk_stb_q;
    assign chk_hit  = (rd_addr[ADDR_W-1 -: SECT_W] == erase_sector);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    // R2
    hold_without_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_rise |=> $stable(rd_data));

    // R4
    prog_status_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_rise && busy && !op_erase && !(suspended && chk_hit))
        |=> (rd_data[7] == !$past(prog_bit)) && (rd_data[2] == 1'b0)
            && (rd_data[15:8] == 8'h00));

    // R6
    susp_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_rise && suspended && chk_hit) |=> (rd_data[7:6] == 2'b11));

    // R8
    idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_rise && !busy && !suspended) |=> (rd_data == $past(arr_data)));
endmodule

bind flash_status_poll flash_status_poll_chk #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_stb       (rd_stb),
    .rd_addr      (rd_addr),
    .arr_data     (arr_data),
    .prog_bit     (prog_bit),
    .busy         (busy),
    .op_erase     (op_erase),
    .suspended    (suspended),
    .erase_sector (erase_sector),
    .rd_data      (rd_data)
);

// File: tb/sim_flash_status_poll.sv
`timescale 1ns/1ps
module sim_flash_status_poll;
    localparam int ADDR_W = 20;
    localparam int SECT_W = 5;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_stb = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] arr_data = '0;
    logic              prog_bit = 1'b0;
    logic              busy = 1'b0;
    logic              op_erase = 1'b0;
    logic              suspended = 1'b0;
    logic [SECT_W-1:0] erase_sector = '0;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic m6 = 1'b0;
    logic m2 = 1'b0;
    logic [DATA_W-1:0] exp_q[$];
    string tag_q[$];
    logic stb_tb = 1'b0;
    logic pend = 1'b0;

    always #5 clk = ~clk;

    flash_status_poll #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W),
        .DATA_W (DATA_W)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .rd_stb       (rd_stb),
        .rd_addr      (rd_addr),
        .arr_data     (arr_data),
        .prog_bit     (prog_bit),
        .busy         (busy),
        .op_erase     (op_erase),
        .suspended    (suspended),
        .erase_sector (erase_sector),
        .rd_data      (rd_data)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: model the expected word, push it, then strobe.
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] arr,
                      input int hold, input string tag);
        logic h;
        logic [DATA_W-1:0] e;
        h = (a[ADDR_W-1:ADDR_W-SECT_W] == erase_sector);
        e = '0;
        if (suspended && h) begin
            m2 = ~m2;
            e[7] = 1'b1; e[6] = 1'b1; e[2] = m2;
        end else if (busy && !op_erase) begin
            m6 = ~m6;
            e[7] = ~prog_bit; e[6] = m6;
        end else if (busy && !suspended) begin
            m6 = ~m6;
            if (h) m2 = ~m2;
            e[6] = m6; e[2] = m2;
        end else begin
            e = arr;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_addr  = a;
        arr_data = arr;
        rd_stb   = 1'b1;
        repeat (hold) @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    // Monitor
    always @(posedge clk) begin
        stb_tb <= rd_stb;
        pend   <= rd_stb && !stb_tb && !rst;
    end

    always @(negedge clk) begin
        if (pend) begin
            logic [DATA_W-1:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected read result %h, expected none", rd_data);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rd_data !== '0) begin
            errors++;
            $display("FAIL R1: reset rd_data %h expected 0000", rd_data);
        end

        // R8 idle reads pass through and do not touch toggles (R3)
        rd(20'h01234, 16'hA5A5, 1, "R8");
        rd(20'h81234, 16'h5A3C, 1, "R8");

        // R4 / R3 / R1 program: first read shows bit6 = 1
        busy = 1'b1; op_erase = 1'b0; prog_bit = 1'b1;
        rd(20'h00010, 16'hFFFF, 1, "R1 R4 R9");
        rd(20'h00010, 16'hFFFF, 1, "R3 R4");
        prog_bit = 1'b0;
        rd(20'h00010, 16'hFFFF, 1, "R3 R4 R9");

        // R2 strobe held high counts once
        rd(20'h00010, 16'h0000, 3, "R2");
        rd(20'h00010, 16'h0000, 1, "R2 R3");

        // R3 idle freezes bit6
        busy = 1'b0;
        rd(20'h00400, 16'h1357, 1, "R8 R3");
        busy = 1'b1;
        rd(20'h00400, 16'h1357, 1, "R3");

        // R5 / R10 erase of sector 3
        op_erase = 1'b1; erase_sector = 5'd3;
        rd({5'd3, 15'h7FFF}, 16'hFFFF, 1, "R5 R9 R10");
        rd({5'd7, 15'h7FFF}, 16'hFFFF, 1, "R5 R10");
        rd({5'd3, 15'h0000}, 16'hFFFF, 1, "R5 R10");
        rd({5'd19, 15'h0000}, 16'hFFFF, 1, "R5 R10");
        rd({5'd3, 15'h1234}, 16'hFFFF, 1, "R5");

        // R6 / R7 suspend, no operation running
        busy = 1'b0; suspended = 1'b1;
        rd({5'd3, 15'h0042}, 16'hFFFF, 1, "R6 R9");
        rd({5'd3, 15'h0042}, 16'hFFFF, 1, "R6");
        rd({5'd4, 15'h0042}, 16'hBEEF, 1, "R7");
        rd({5'd0, 15'h0000}, 16'h0F0F, 1, "R7");

        // R4 / R6 program elsewhere while suspended
        busy = 1'b1; op_erase = 1'b0; prog_bit = 1'b1;
        rd({5'd9, 15'h0001}, 16'hFFFF, 1, "R4 R3");
        rd({5'd3, 15'h0001}, 16'hFFFF, 1, "R6");
        rd({5'd9, 15'h0001}, 16'hFFFF, 1, "R4 R3");

        // back to idle
        busy = 1'b0; suspended = 1'b0;
        rd(20'hFFFFF, 16'hC3C3, 1, "R8");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d reads unanswered, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule